// File: doc/BRIEF.md
# Masked Region Address Decoder

This block decides which of several programmable external-memory windows a 32-bit bus address falls into. Each window is described by one configuration word: a 20-bit page base (address bits 31..12), a 4-bit size code, a second accepted value for the top address nibble with its own enable, a window enable and a write-protect flag. The configuration words are loaded through a small write-only register port.

For every valid access, the decoder compares the address with all windows in parallel. One clock edge later it presents a vector of hit flags, the index of the lowest-numbered window that hit, and a one-cycle error flag. The error flag is raised when a write was refused because it targeted a write-protected window. A bus controller uses the index to pick the chip select and the timing set for the access, and uses the error flag to end a refused write.

Top module: `mrd_decoder`

## Requirements
- R1: After reset every window is disabled and all outputs (`hit_vec`, `hit_idx`, `idx_valid`, `prot_err`) are zero. A valid access made before any configuration write hits nothing.
- R2: A window's segment test passes when address bits 31..28 equal base bits 19..16. Base bit k corresponds to address bit k+12.
- R3: The segment test also passes when address bits 31..28 equal the alternate segment field, but only while the alternate-enable bit is 1.
- R4: Address bit 27 is always compared with base bit 15, whatever the size code.
- R5: A size code N compares the N address bits A[26:27−N] with the matching base bits. The window then spans 2^(27−N) bytes, from 128 Mbyte at N=0 to 4 Kbyte at N=15. An address hits exactly when it lies in [start, start+size) of a start that is aligned to the size.
- R6: A window whose enable bit is 0 never hits.
- R7: A write access never hits a window whose write-protect bit is 1. A read access to the same window still hits.
- R8: `prot_err` is 1 for exactly the one cycle after a valid write whose address matches an enabled, write-protected window. Otherwise it is 0.
- R9: When several windows hit, `hit_idx` is the lowest hitting index. `idx_valid` is 1 exactly when `hit_vec` is non-zero.
- R10: All outputs are registered and describe the access presented one clock edge earlier. A cycle with `in_valid` low yields all-zero outputs on the next cycle.
- R11: A pulse on `cfg_we` loads window `cfg_idx`, with the new setting used from the next cycle. The word layout is: `cfg_wdata[30:11]` base, `[10:7]` size code, `[6:3]` alternate segment, `[2]` alternate enable, `[1]` write protect, `[0]` enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Window selected for the configuration write |
| cfg_wdata | input | 31 | Configuration word |
| in_valid | input | 1 | Access present |
| in_wr | input | 1 | Access is a write |
| in_addr | input | 32 | Access address |
| hit_vec | output | NREG | Per-window hit flags |
| hit_idx | output | IDXW | Lowest hitting window |
| idx_valid | output | 1 | At least one window hit |
| prot_err | output | 1 | Write refused by write protection |

## Verification
Every decode result is due on the first clock edge after the access is presented. The bench drives each access on a falling edge and reads all four outputs just after the next rising edge. It then drops `in_valid` for one cycle and reads the outputs again, which shows that the error flag is a single-cycle pulse and that an idle cycle clears the result. A configuration word is written one full cycle before the access that relies on it. For each size code, the expected hits come from comparing the address against the window's start and start+size, not from the bit-mask view.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  // Configuration word of one window; field order is the register layout.
  typedef struct packed {
    logic [19:0] base;     // address bits 31..12
    logic [3:0]  size_n;   // number of bits compared below bit 27
    logic [3:0]  alt_seg;  // second accepted top nibble
    logic        alt_en;
    logic        wprot;
    logic        en;
  } region_cfg_t;

  localparam int CFG_W = $bits(region_cfg_t);

  // Thermometer of compared bits over A[26:12]; top n bits set.
  function automatic logic [14:0] span_mask(input logic [3:0] n);
    span_mask = ~(15'h7fff >> n);
  endfunction

  // Segment test on the top nibble: main base, or alternate when enabled.
  function automatic logic seg_match(input region_cfg_t c, input logic [3:0] nib);
    seg_match = (nib == c.base[19:16]) || (c.alt_en && (nib == c.alt_seg));
  endfunction

  // Full address compare for a page number (address bits 31..12).
  function automatic logic page_match(input region_cfg_t c, input logic [19:0] page);
    logic b27;
    logic low;
    b27 = (page[15] == c.base[15]);
    low = (((page[14:0] ^ c.base[14:0]) & span_mask(c.size_n)) == 15'd0);
    page_match = seg_match(c, page[19:16]) && b27 && low;
  endfunction

endpackage

// File: rtl/mrd_cfg_bank.sv
module mrd_cfg_bank
  import mrd_pkg::*;
#(
  parameter int NREG = 4,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output region_cfg_t       cfg_q [NREG]
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic sel_w;
    assign sel_w = cfg_we && (cfg_idx == IDXW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q[i] <= '0;
      else if (sel_w) cfg_q[i] <= region_cfg_t'(cfg_wdata);
    end
  end

endmodule

// File: rtl/mrd_region_match.sv
module mrd_region_match
  import mrd_pkg::*;
(
  input  region_cfg_t cfg,
  input  logic [19:0] page,
  input  logic        wr,
  output logic        addr_hit,  // address matches an enabled window
  output logic        sel,       // window selected for this access
  output logic        blocked    // write refused by protection
);

  assign addr_hit = cfg.en && page_match(cfg, page);
  assign blocked  = addr_hit && wr && cfg.wprot;
  assign sel      = addr_hit && !blocked;

endmodule

// File: rtl/mrd_lowest_pick.sv
module mrd_lowest_pick #(
  parameter int NREG = 4,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0] req,
  output logic [IDXW-1:0] idx,
  output logic            any
);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/mrd_decoder.sv
module mrd_decoder
  import mrd_pkg::*;
#(
  parameter int NREG = 4,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [30:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic              in_wr,
  input  logic [31:0]       in_addr,
  output logic [NREG-1:0]   hit_vec,
  output logic [IDXW-1:0]   hit_idx,
  output logic              idx_valid,
  output logic              prot_err
);

  region_cfg_t     cfg_q [NREG];
  logic [NREG-1:0] addr_hit_w;
  logic [NREG-1:0] sel_w;
  logic [NREG-1:0] blocked_w;
  logic [NREG-1:0] en_vec_w;
  logic [NREG-1:0] wprot_vec_w;
  logic [IDXW-1:0] pick_idx_w;
  logic            pick_any_w;
  logic            unused_low_bits;

  assign unused_low_bits = ^in_addr[11:0];

  mrd_cfg_bank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_win
    mrd_region_match u_match (
      .cfg      (cfg_q[i]),
      .page     (in_addr[31:12]),
      .wr       (in_wr),
      .addr_hit (addr_hit_w[i]),
      .sel      (sel_w[i]),
      .blocked  (blocked_w[i])
    );
    assign en_vec_w[i]    = cfg_q[i].en;
    assign wprot_vec_w[i] = cfg_q[i].wprot;
  end

  mrd_lowest_pick #(.NREG(NREG)) u_pick (
    .req (sel_w),
    .idx (pick_idx_w),
    .any (pick_any_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_vec   <= '0;
      hit_idx   <= '0;
      idx_valid <= 1'b0;
      prot_err  <= 1'b0;
    end else if (in_valid) begin
      hit_vec   <= sel_w;
      hit_idx   <= pick_idx_w;
      idx_valid <= pick_any_w;
      prot_err  <= |blocked_w;
    end else begin
      hit_vec   <= '0;
      hit_idx   <= '0;
      idx_valid <= 1'b0;
      prot_err  <= 1'b0;
    end
  end

  // R9
  idx_flags_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid == (hit_vec != '0));

  // R9
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> (hit_vec[hit_idx] &&
                   ((hit_vec & ((NREG'(1) << hit_idx) - NREG'(1))) == '0)));

  // R10
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (hit_vec == '0 && !idx_valid && !prot_err));

  // R6
  disabled_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((hit_vec & ~$past(en_vec_w)) == '0));

  // R7
  no_write_to_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_wr) |=> ((hit_vec & $past(wprot_vec_w)) == '0));

  // R8
  err_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> ($past(in_valid) && $past(in_wr)));

  // R8
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wr) |=> !prot_err);

endmodule

// File: tb/tb_mrd_decoder.sv
module tb_mrd_decoder;
  localparam int NREG = 4;
  localparam int IDXW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [IDXW-1:0] cfg_idx = '0;
  logic [30:0]     cfg_wdata = '0;
  logic            in_valid = 1'b0;
  logic            in_wr = 1'b0;
  logic [31:0]     in_addr = '0;
  logic [NREG-1:0] hit_vec;
  logic [IDXW-1:0] hit_idx;
  logic            idx_valid;
  logic            prot_err;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mrd_decoder #(.NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_wr(in_wr),
    .in_addr(in_addr), .hit_vec(hit_vec), .hit_idx(hit_idx),
    .idx_valid(idx_valid), .prot_err(prot_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R11 layout: base[30:11] size[10:7] alt[6:3] alt_en[2] wprot[1] en[0]
  function automatic logic [30:0] word(input logic [19:0] base, input logic [3:0] n,
                                       input logic [3:0] alt, input logic alt_en,
                                       input logic wp, input logic en);
    return {base, n, alt, alt_en, wp, en};
  endfunction

  task automatic cfg(input int idx, input logic [30:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDXW'(idx); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Present one access, check result one edge later, then an idle cycle.
  task automatic access(input string req, input logic [31:0] a, input logic w,
                        input logic [NREG-1:0] exp_vec, input logic exp_err);
    int exp_idx;
    exp_idx = 0;
    for (int i = NREG - 1; i >= 0; i--) if (exp_vec[i]) exp_idx = i;
    @(negedge clk);
    in_addr = a; in_wr = w; in_valid = 1'b1;
    @(posedge clk); #1;
    check(req, hit_vec, exp_vec);
    check(req, idx_valid, exp_vec != 0);
    if (exp_vec != 0) check(req, hit_idx, exp_idx);
    check(req, prot_err, exp_err);
    @(negedge clk);
    in_valid = 1'b0; in_wr = 1'b0;
    @(posedge clk); #1;
    check("R10/R8 idle", {hit_vec, idx_valid, prot_err}, 0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {hit_vec, hit_idx, idx_valid, prot_err}, 0);
    rst_n = 1'b1;
    access("R1 all disabled", 32'h0000_0000, 1'b0, 4'b0000, 1'b0);
    access("R1 all disabled", 32'hA800_0000, 1'b0, 4'b0000, 1'b0);

    // R5 sweep of every size code on window 0, R4 at the edges.
    for (int n = 0; n < 16; n++) begin
      longint size;
      longint s;
      longint probes [5];
      size = 64'd1 << (27 - n);
      s = 64'hA800_0000 + ((n >= 2) ? 3 * size : 0);
      cfg(0, word(s[31:12], 4'(n), 4'h0, 1'b0, 1'b0, 1'b1));
      probes[0] = s; probes[1] = s + size - 1; probes[2] = s - 1;
      probes[3] = s + size; probes[4] = s + size / 2;
      for (int p = 0; p < 5; p++) begin
        logic e;
        e = (probes[p] >= s) && (probes[p] < s + size);
        access("R5 boundary", probes[p][31:0], 1'b0, {3'b000, e}, 1'b0);
      end
    end

    // R4: bit 27 flipped misses even with the largest window.
    cfg(0, word(20'hA8000, 4'd0, 4'h0, 1'b0, 1'b0, 1'b1));
    access("R4 bit27", 32'hA000_1000, 1'b0, 4'b0000, 1'b0);
    access("R4 bit27", 32'hAFFF_FFFF, 1'b0, 4'b0001, 1'b0);
    // R2: top nibble mismatch.
    access("R2 segment", 32'hB800_0000, 1'b0, 4'b0000, 1'b0);

    // R3 alternate segment.
    cfg(0, word(20'h10000, 4'd15, 4'h6, 1'b1, 1'b0, 1'b1));
    access("R2 main nibble", 32'h1000_0ABC, 1'b0, 4'b0001, 1'b0);
    access("R3 alt enabled", 32'h6000_0ABC, 1'b0, 4'b0001, 1'b0);
    access("R3 other nibble", 32'h7000_0ABC, 1'b0, 4'b0000, 1'b0);
    cfg(0, word(20'h10000, 4'd15, 4'h6, 1'b0, 1'b0, 1'b1));
    access("R3 alt disabled", 32'h6000_0ABC, 1'b0, 4'b0000, 1'b0);

    // R6 enable bit.
    cfg(0, word(20'h10000, 4'd15, 4'h6, 1'b0, 1'b0, 1'b0));
    access("R6 disabled", 32'h1000_0ABC, 1'b0, 4'b0000, 1'b0);

    // R9 priority with overlap: windows 1 and 2, window 3 disabled.
    cfg(1, word(20'hA8000, 4'd0, 4'h0, 1'b0, 1'b0, 1'b1));
    cfg(2, word(20'hA8123, 4'd15, 4'h0, 1'b0, 1'b0, 1'b1));
    cfg(3, word(20'hA8123, 4'd15, 4'h0, 1'b0, 1'b0, 1'b0));
    access("R9 overlap", 32'hA812_3456, 1'b0, 4'b0110, 1'b0);
    access("R9 single", 32'hA812_4000, 1'b1, 4'b0010, 1'b0);

    // R7/R8 write protection on window 1.
    cfg(1, word(20'hA8000, 4'd0, 4'h0, 1'b0, 1'b1, 1'b1));
    access("R7/R8 write blocked", 32'hA812_3456, 1'b1, 4'b0100, 1'b1);
    access("R7 read allowed", 32'hA812_3456, 1'b0, 4'b0110, 1'b0);
    access("R8 only ro target", 32'hA812_4000, 1'b1, 4'b0000, 1'b1);
    access("R8 no match", 32'h2000_0000, 1'b1, 4'b0000, 1'b0);

    // R11: new setting used from the next cycle (window 3 enable).
    cfg(3, word(20'hA8123, 4'd15, 4'h0, 1'b0, 1'b0, 1'b1));
    access("R11 load", 32'hA812_3000, 1'b0, 4'b1110, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule